// File: doc/BRIEF.md
# Direct-Mapped Instruction Cache

This block sits between a processor's fetch port and a slow external memory and keeps recently fetched longwords so that repeated instruction fetches and PC-relative constant loads are answered without a memory cycle. It is direct mapped. There are 256 lines of one 32-bit longword each, which gives 1 kbyte of data. Each line holds two 16-bit instructions. Tags, data and per-line valid bits are kept in internal register arrays.

A request carries a 32-bit address, a write flag and a flag that marks the access as an instruction fetch or a PC-relative read. Only requests carrying that flag are looked up or filled. Plain data reads and all writes go straight to memory and never allocate a line. The on-chip RAM window and the on-chip I/O window are never cached. A hit is acknowledged in the cycle of the request. A miss starts one memory read the following cycle. When memory answers, the longword is forwarded to the processor and stored in the line in the same cycle. Dropping the enable input, or pulsing the invalidate input, empties the whole cache in a single cycle.

Top module: `icache_dm`

## Requirements
- R1: While reset is asserted, and after it, no line is valid and both `cpu_ack` and `mem_req` stay low.
- R2: A cacheable request that hits a valid line with a matching tag sees `cpu_ack` high in the request cycle. That cycle carries the stored longword and leaves `mem_req` low. A request is cacheable when `cache_en`=1, `cpu_inst`=1 and `cpu_we`=0, and its address lies in neither on-chip window.
- R3: A request that does not hit raises `mem_req` from the next cycle. `mem_addr` equals `cpu_addr`. When `mem_ack` arrives, `cpu_ack` rises in that same cycle with `cpu_rdata` equal to `mem_rdata`. If the request is cacheable, the line is filled with that word.
- R4: The line index is address bits [9:2] and the tag is bits [31:10]. Bits [1:0] do not take part in the lookup. Two addresses that share an index but differ in tag evict each other.
- R5: A read with `cpu_inst`=0 always goes to memory and allocates no line.
- R6: A write (`cpu_we`=1) is passed to memory with `mem_we`=1 and `mem_wdata`=`cpu_wdata`. It neither allocates nor changes any line.
- R7: Addresses with bits [31:12]=0xFFFFF (on-chip RAM) or bits [31:14] matching 0xFFFF8000 (on-chip I/O) always go to memory and are never filled, even with `cpu_inst`=1.
- R8: While `cache_en`=0, no request hits and every line is invalidated. After re-enabling, the first access to any address misses.
- R9: `inv_all`=1 invalidates every line at the next edge. If it coincides with a fill, the invalidation wins and the line stays empty.
- R10: `mem_req` stays high until `mem_ack`. Each request gets exactly one `cpu_ack`, for any memory latency including an answer in the first memory cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cache_en | input | 1 | Cache enable; low invalidates and bypasses |
| inv_all | input | 1 | Invalidate every line |
| cpu_req | input | 1 | Request, held until acknowledged |
| cpu_we | input | 1 | Request is a write |
| cpu_inst | input | 1 | Request is an instruction fetch or PC-relative read |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Write data |
| cpu_ack | output | 1 | Request complete |
| cpu_rdata | output | 32 | Read data, valid with `cpu_ack` |
| mem_req | output | 1 | External memory request |
| mem_we | output | 1 | External memory write |
| mem_addr | output | 32 | External memory address |
| mem_wdata | output | 32 | External memory write data |
| mem_rdata | input | 32 | External memory read data |
| mem_ack | input | 1 | External memory completion |

## Verification
The hardest case to reach from the ports is an invalidation that lands in the very cycle a fill completes. It needs `inv_all` high while the memory answer arrives for a cacheable miss. The bench holds `inv_all` through a whole cacheable miss and then fetches the same address again, which must miss. Stale hits are told apart from memory reads by changing the bench memory's contents between accesses. A hit then returns the old word and a memory read returns the new one. Latencies of zero and several cycles and same-index aliases cover the eviction and handshake timing.

// File: rtl/icache_dm.sv
module icache_dm #(
  parameter int          ADDR_W   = 32,
  parameter int          DATA_W   = 32,
  parameter int          IDX_W    = 8,
  parameter int          OFF_W    = 2,
  parameter logic [31:0] RAM_BASE = 32'hFFFF_F000,
  parameter logic [31:0] RAM_MASK = 32'hFFFF_F000,
  parameter logic [31:0] IO_BASE  = 32'hFFFF_8000,
  parameter logic [31:0] IO_MASK  = 32'hFFFF_C000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cache_en,
  input  logic              inv_all,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic              cpu_inst,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ack,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ack
);
  localparam int LINES = 1 << IDX_W;
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

  logic [LINES-1:0]  valid;
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES];
  logic              busy;

  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] tag;
  logic             onchip, cacheable, hit, fill;

  assign idx       = cpu_addr[OFF_W +: IDX_W];
  assign tag       = cpu_addr[ADDR_W-1 -: TAG_W];
  assign onchip    = ((cpu_addr & RAM_MASK[ADDR_W-1:0]) == RAM_BASE[ADDR_W-1:0]) ||
                     ((cpu_addr & IO_MASK[ADDR_W-1:0])  == IO_BASE[ADDR_W-1:0]);
  assign cacheable = cache_en && cpu_inst && !cpu_we && !onchip;
  assign hit       = cacheable && valid[idx] && (tag_q[idx] == tag);
  assign fill      = busy && mem_ack && cacheable && !inv_all;

  assign cpu_ack   = cpu_req && (busy ? mem_ack : hit);
  assign cpu_rdata = busy ? mem_rdata : data_q[idx];
  assign mem_req   = busy;
  assign mem_we    = busy && cpu_we;
  assign mem_addr  = cpu_addr;
  assign mem_wdata = cpu_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      busy <= 1'b0;
    else if (!busy)  busy <= cpu_req && !hit;
    else if (mem_ack) busy <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    valid <= '0;
    else if (!cache_en || inv_all) valid <= '0;
    else if (fill)                 valid[idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (fill) begin
      tag_q[idx]  <= tag;
      data_q[idx] <= mem_rdata;
    end
  end
endmodule

// File: rtl/icache_dm_chk.sv
module icache_dm_chk (
  input logic clk,
  input logic rst_n,
  input logic cache_en,
  input logic inv_all,
  input logic cpu_req,
  input logic cpu_we,
  input logic cpu_inst,
  input logic cpu_ack,
  input logic mem_req,
  input logic mem_we,
  input logic mem_ack
);
  always @(posedge clk)
    if (!rst_n) assert_quiet_in_reset_R1: assert (!cpu_ack && !mem_req)
      else $error("R1 outputs active during reset");

  assert_hit_only_cacheable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ack && !mem_req) |-> (cpu_req && cpu_inst && !cpu_we && cache_en));

  assert_ack_with_mem_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack && cpu_req) |-> cpu_ack);

  assert_no_hit_data_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && !cpu_inst && !mem_req) |-> !cpu_ack);

  assert_write_forwarded_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && cpu_we) |-> mem_we);

  assert_disabled_no_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cache_en |-> !(cpu_ack && !mem_req));

  assert_inv_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> !(cpu_ack && !mem_req));

  assert_req_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> mem_req);

  assert_single_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack) |=> !mem_req);
endmodule

bind icache_dm icache_dm_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cache_en(cache_en), .inv_all(inv_all),
  .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_inst(cpu_inst), .cpu_ack(cpu_ack),
  .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack)
);

// File: tb/icache_dm_tb.sv
`timescale 1ns/1ps
module icache_dm_tb;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, cache_en, inv_all, cpu_req, cpu_we, cpu_inst, mem_ack;
  logic [31:0] cpu_addr, cpu_wdata, mem_rdata;
  logic cpu_ack, mem_req, mem_we;
  logic [31:0] cpu_rdata, mem_addr, mem_wdata;

  icache_dm u_dut (.*);

  int vectors = 0, miscompares = 0;
  bit mv [256];
  logic [21:0] mt [256];
  logic [31:0] md [256];
  bit mbusy = 0;
  int mcnt = 0, lat = 0;
  logic [31:0] gen = 32'h1234_0000;

  function automatic logic [31:0] memf(logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ gen;
  endfunction

  function automatic bit onchip(logic [31:0] a);
    return ((a & 32'hFFFF_F000) == 32'hFFFF_F000) || ((a & 32'hFFFF_C000) == 32'hFFFF_8000);
  endfunction

  task automatic cyc(input string rq, output bit acked);
    bit cach, hit, eack, fill, bad;
    logic [31:0] edata;
    int idx;
    mem_ack   = mbusy && (mcnt == lat);
    mem_rdata = memf(cpu_addr);
    #1;
    idx   = int'(cpu_addr[9:2]);
    cach  = cache_en && cpu_inst && !cpu_we && !onchip(cpu_addr);
    hit   = !mbusy && cpu_req && cach && mv[idx] && (mt[idx] == cpu_addr[31:10]);
    eack  = cpu_req && (mbusy ? mem_ack : hit);
    edata = mbusy ? mem_rdata : md[idx];
    bad = (cpu_ack !== eack) || (mem_req !== mbusy) ||
          (eack && !cpu_we && cpu_rdata !== edata) ||
          (mbusy && (mem_we !== cpu_we || mem_addr !== cpu_addr ||
                     (cpu_we && mem_wdata !== cpu_wdata)));
    vectors++;
    if (bad) begin
      miscompares++;
      $display("FAIL %s: ack=%0b/%0b mem_req=%0b/%0b rdata=%h/%h mem_we=%0b/%0b mem_addr=%h/%h",
               rq, cpu_ack, eack, mem_req, mbusy, cpu_rdata, edata, mem_we, cpu_we, mem_addr, cpu_addr);
    end
    fill  = mbusy && mem_ack && cach && !inv_all;
    acked = eack;
    @(posedge clk);
    if (!cache_en || inv_all) begin
      foreach (mv[i]) mv[i] = 0;
    end else if (fill) begin
      mv[idx] = 1; mt[idx] = cpu_addr[31:10]; md[idx] = mem_rdata;
    end
    if (!mbusy) begin
      if (cpu_req && !hit) begin mbusy = 1; mcnt = 0; end
    end else if (mem_ack) mbusy = 0;
    else mcnt++;
    @(negedge clk);
  endtask

  task automatic access(input logic [31:0] a, input bit inst, input bit we, input int l,
                        input string rq);
    bit done = 0;
    lat = l;
    cpu_req = 1; cpu_addr = a; cpu_inst = inst; cpu_we = we; cpu_wdata = a ^ 32'h5A5A_A5A5;
    while (!done) cyc(rq, done);
    cpu_req = 0; cpu_we = 0;
    cyc(rq, done);
    gen = gen + 32'h0001_0101;
  endtask

  task automatic idle(input string rq);
    bit d;
    cyc(rq, d);
  endtask

  initial begin
    #(200000 * 5);
    miscompares++;
    $display("FAIL watchdog: run did not complete / expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    rst_n = 0; cache_en = 1; inv_all = 0; cpu_req = 0; cpu_we = 0; cpu_inst = 0;
    cpu_addr = 0; cpu_wdata = 0; mem_ack = 0; mem_rdata = 0;
    foreach (mv[i]) mv[i] = 0;
    @(negedge clk);
    cpu_req = 1; cpu_inst = 1; cpu_addr = 32'h0000_1000;
    for (int i = 0; i < 3; i++) begin
      #1;
      vectors++;
      if (cpu_ack !== 1'b0 || mem_req !== 1'b0) begin
        miscompares++;
        $display("FAIL R1: ack=%0b/0 mem_req=%0b/0", cpu_ack, mem_req);
      end
      @(negedge clk);
    end
    cpu_req = 0;
    rst_n = 1;
    idle("R1");

    access(32'h0000_1000, 1, 0, 2, "R3 first fetch miss");
    access(32'h0000_1000, 1, 0, 2, "R2 hit returns stored word");
    access(32'h0000_1002, 1, 0, 2, "R4 offset ignored");
    access(32'h0000_1400, 1, 0, 1, "R4 alias evicts");
    access(32'h0000_1000, 1, 0, 1, "R4 evicted line misses");
    access(32'h0000_1000, 1, 0, 1, "R2 refilled hit");

    access(32'h0000_2010, 0, 0, 1, "R5 data read");
    access(32'h0000_2010, 1, 0, 1, "R5 no allocation from data read");

    access(32'h0000_1000, 1, 1, 1, "R6 write passthrough");
    access(32'h0000_1000, 1, 0, 1, "R6 line unchanged by write");

    access(32'hFFFF_F100, 1, 0, 1, "R7 on-chip RAM");
    access(32'hFFFF_F100, 1, 0, 1, "R7 on-chip RAM again");
    access(32'hFFFF_8204, 1, 0, 1, "R7 on-chip I/O");
    access(32'hFFFF_8204, 1, 0, 1, "R7 on-chip I/O again");

    cache_en = 0;
    access(32'h0000_1000, 1, 0, 1, "R8 disabled bypass");
    access(32'h0000_1000, 1, 0, 1, "R8 disabled no fill");
    cache_en = 1;
    access(32'h0000_1000, 1, 0, 1, "R8 miss after re-enable");
    access(32'h0000_1000, 1, 0, 1, "R8 hit after refill");

    access(32'h0000_3008, 1, 0, 1, "R9 fill before invalidate");
    inv_all = 1; idle("R9"); inv_all = 0;
    access(32'h0000_3008, 1, 0, 1, "R9 miss after invalidate");
    inv_all = 1;
    access(32'h0000_300C, 1, 0, 2, "R9 invalidate during fill");
    inv_all = 0;
    access(32'h0000_300C, 1, 0, 1, "R9 fill suppressed");

    access(32'h0000_4000, 1, 0, 0, "R10 zero latency");
    access(32'h0000_4004, 1, 0, 5, "R10 long latency");
    access(32'h0000_4008, 1, 1, 0, "R10 zero latency write");

    for (int k = 0; k < 24; k++)
      access(32'h0001_0000 + 32'(k * 68), 1, 0, k % 3, "R3 sweep fill");
    for (int k = 0; k < 24; k++)
      access(32'h0001_0000 + 32'(k * 68), 1, 0, 1, "R2 sweep hit");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule